// File: doc/BRIEF.md
# Serial Control Slave for a Clock Generator Register File

This block connects a clock generator's six control bytes to a two-wire serial bus. It acts only as a slave. Bus clock and data are sampled with a fast system clock, which must run at least twenty times the 100 kHz bus rate. The block finds start and stop conditions on the sampled lines and answers one fixed 7-bit device address. The address byte ends in 0 for a write and in 1 for a read.

A write frame carries a command byte and a count byte. The block ignores the value of both but still acknowledges them. The bytes that follow fill the control bytes in order, starting at byte 0. The block has no sub-addressing. A read frame returns the number of control bytes first and then the control bytes from byte 0 upward. The six bytes appear as one parallel output with fixed power-up values. While power-down is asserted, the block ignores the bus and keeps every control byte.

Top module: `clkgen_ctl_slave`

## Requirements
- R1: After reset, control byte k sits on ctl_bytes_o[8k+7:8k], and the values are 0xF6, 0x3F, 0xE0, 0x7E, 0x00, 0x00 for k = 0 to 5.
- R2: Only the address bytes 0xD2 (write) and 0xD3 (read) are acknowledged. After any other address byte, the block acknowledges nothing and changes nothing until the next start.
- R3: In a write, the first two bytes after the address are acknowledged and discarded. Each later byte is taken MSB first and stored into control bytes 0, 1, 2 and so on. A control byte changes only while the bus clock is low.
- R4: The block acknowledges each accepted byte by pulling the data line low for the whole ninth clock. sda_pull_o = 1 means "pull low". The block never drives the line high, and the pull changes only while the bus clock is low.
- R5: A write frame accepts at most 10 bytes after the command and count bytes. Bytes 7 to 10 are acknowledged and thrown away. The 11th byte is not acknowledged, and the block ignores the rest of the frame.
- R6: A read frame sends the value 6, then control bytes 0 to 5, then 0x00 for every later byte, all MSB first. It keeps sending while the master acknowledges.
- R7: When the master does not acknowledge a read byte, the block releases the line. The line stays released for all further clocks until a stop or a start.
- R8: While pwr_dn = 1, the block ignores the bus: it sends no acknowledge and does no write. All control bytes keep their values through power-down and after it ends.
- R9: A repeated start in the middle of a frame begins a new address phase. A write frame followed by a repeated start and a read frame returns the freshly written bytes.
- R10: A stop ends the frame. Bytes already stored stay stored, and control bytes the frame did not reach keep their earlier values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 20x the bus bit rate |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_dn | input | 1 | Power-down; 1 = ignore the bus and hold the registers |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired line) |
| sda_pull_o | output | 1 | 1 = pull the data line low; 0 = release it |
| ctl_bytes_o | output | 48 | Control bytes; byte k is on bits [8k+7:8k] |

## Verification
Random write frames use random lengths from 0 to 10 and random data. Each is followed by a read-back of random length. This separates correct byte ordering and count handling from a shift or an off-by-one in the position counter. Directed frames target specific faults:
- A foreign address, and one that differs from the device address only in the low bit, catch a loose address compare.
- An 11-byte write locates the acknowledge limit and the discard of bytes beyond the sixth.
- A repeated start, a stop in the middle of a frame, a master NACK followed by extra clocks, and traffic during power-down each check a separate way a frame can end.

// File: rtl/clkgen_ctl_pkg.sv
// Shared types and power-up values for the clock generator control slave.
package clkgen_ctl_pkg;

    // Frame states of the serial link engine.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } link_st_t;

    // Power-up value of control byte idx.
    function automatic logic [7:0] reg_default(input int idx);
        case (idx)
            0:       return 8'hF6;
            1:       return 8'h3F;
            2:       return 8'hE0;
            3:       return 8'h7E;
            default: return 8'h00;
        endcase
    endfunction

endpackage

// File: rtl/bus_line_sync.sv
// Synchronises the bus clock and data lines into the system clock domain.
// Produces one-cycle pulses for clock edges and for start/stop conditions.
// Assumes the system clock is far faster than the bus so that no bus
// transition is shorter than SYNC_STAGES+1 system cycles.
module bus_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [SYNC_STAGES:0] scl_pipe;
    logic [SYNC_STAGES:0] sda_pipe;
    logic scl_cur, scl_prev, sda_cur, sda_prev;

    // Shift both lines through the synchroniser and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
        end else begin
            scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_i};
            sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_i};
        end
    end

    assign scl_cur  = scl_pipe[SYNC_STAGES-1];
    assign scl_prev = scl_pipe[SYNC_STAGES];
    assign sda_cur  = sda_pipe[SYNC_STAGES-1];
    assign sda_prev = sda_pipe[SYNC_STAGES];

    // Edge and condition decode from the current and previous samples.
    always_comb begin
        sda_lvl   = sda_cur;
        scl_rise  = scl_cur & ~scl_prev;
        scl_fall  = ~scl_cur & scl_prev;
        start_det = scl_cur & scl_prev & sda_prev & ~sda_cur;
        stop_det  = scl_cur & scl_prev & ~sda_prev & sda_cur;
    end

endmodule

// File: rtl/link_engine.sv
// Frame engine: address match, byte receive and acknowledge, read transmit.
// Assumes the edge/condition pulses come from bus_line_sync. bit_cnt counts
// bus clock rises in a byte: 1..8 data bits, 9 the acknowledge clock.
module link_engine
    import clkgen_ctl_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h69,
    parameter int NREGS  = 6,
    parameter int MAX_WR = 10,
    parameter int CNT_W  = 4,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pwr_dn,
    input  logic             sda_lvl,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [7:0]       rd_byte,
    output logic             sda_pull,
    output logic             wr_en,
    output logic [IDX_W-1:0] wr_idx,
    output logic [7:0]       wr_data,
    output logic [CNT_W-1:0] byte_pos
);

    localparam logic [CNT_W-1:0] LAST_ACK = CNT_W'(MAX_WR + 2);
    localparam logic [CNT_W-1:0] FIRST_WR = CNT_W'(2);
    localparam logic [CNT_W-1:0] END_WR   = CNT_W'(NREGS + 2);

    link_st_t   state;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;
    logic       rd_mode;
    logic       mack;

    // Frame sequencing; every bus action keys off a synchronised edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            rd_mode  <= 1'b0;
            mack     <= 1'b0;
            sda_pull <= 1'b0;
            wr_en    <= 1'b0;
            wr_idx   <= '0;
            wr_data  <= '0;
            byte_pos <= '0;
        end else begin
            wr_en <= 1'b0;
            if (pwr_dn) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end else if (start_det) begin
                state    <= ST_ADDR;
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
                byte_pos <= '0;
            end else if (stop_det) begin
                state    <= ST_IDLE;
                sda_pull <= 1'b0;
                bit_cnt  <= '0;
            end else begin
                case (state)
                    ST_ADDR, ST_WDATA: begin
                        if (scl_rise) begin
                            if (bit_cnt < 4'd8) shreg <= {shreg[6:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (state == ST_ADDR) begin
                                if (shreg[7:1] == DEV_ADDR) begin
                                    sda_pull <= 1'b1;
                                    rd_mode  <= shreg[0];
                                end else begin
                                    state   <= ST_WAIT;
                                    bit_cnt <= '0;
                                end
                            end else if (byte_pos < LAST_ACK) begin
                                sda_pull <= 1'b1;
                                if (byte_pos >= FIRST_WR && byte_pos < END_WR) begin
                                    wr_en   <= 1'b1;
                                    wr_idx  <= IDX_W'(byte_pos - FIRST_WR);
                                    wr_data <= shreg;
                                end
                            end else begin
                                state   <= ST_WAIT;
                                bit_cnt <= '0;
                            end
                        end else if (scl_fall && bit_cnt == 4'd9) begin
                            sda_pull <= 1'b0;
                            bit_cnt  <= '0;
                            if (state == ST_ADDR) begin
                                if (rd_mode) begin
                                    state    <= ST_RDATA;
                                    shreg    <= rd_byte;
                                    sda_pull <= ~rd_byte[7];
                                end else begin
                                    state <= ST_WDATA;
                                end
                            end else begin
                                byte_pos <= byte_pos + CNT_W'(1);
                            end
                        end
                    end
                    ST_RDATA: begin
                        if (scl_rise) begin
                            if (bit_cnt == 4'd8) mack <= ~sda_lvl;
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall) begin
                            if (bit_cnt >= 4'd1 && bit_cnt <= 4'd7) begin
                                shreg    <= {shreg[6:0], 1'b0};
                                sda_pull <= ~shreg[6];
                            end else if (bit_cnt == 4'd8) begin
                                sda_pull <= 1'b0;
                                if (byte_pos != '1) byte_pos <= byte_pos + CNT_W'(1);
                            end else if (bit_cnt == 4'd9) begin
                                bit_cnt <= '0;
                                if (mack) begin
                                    shreg    <= rd_byte;
                                    sda_pull <= ~rd_byte[7];
                                end else begin
                                    state    <= ST_WAIT;
                                    sda_pull <= 1'b0;
                                end
                            end
                        end
                    end
                    default: begin
                        sda_pull <= 1'b0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/ctl_reg_bank.sv
// Control byte storage with fixed power-up values, plus the read stream mux.
// Assumes one write per cycle; position 0 of the read stream is the count.
module ctl_reg_bank
    import clkgen_ctl_pkg::*;
#(
    parameter int NREGS = 6,
    parameter int CNT_W = 4,
    parameter int IDX_W = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [7:0]         wr_data,
    input  logic [CNT_W-1:0]   rd_pos,
    output logic [7:0]         rd_byte,
    output logic [NREGS*8-1:0] regs_flat
);

    for (genvar g = 0; g < NREGS; g++) begin : g_byte
        logic [7:0] r;
        // Hold one control byte; load it when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n)                                r <= reg_default(g);
            else if (wr_en && wr_idx == IDX_W'(g))     r <= wr_data;
        end
        assign regs_flat[g*8 +: 8] = r;
    end

    // Select the byte for the current read position.
    always_comb begin
        rd_byte = 8'h00;
        if (rd_pos == '0) rd_byte = 8'(NREGS);
        for (int i = 0; i < NREGS; i++) begin
            if (rd_pos == CNT_W'(i + 1)) rd_byte = regs_flat[i*8 +: 8];
        end
    end

endmodule

// File: rtl/clkgen_ctl_slave.sv
// Top: two-wire serial slave giving write and read access to the
// clock generator control bytes. Assumes clk >= 20x the bus bit rate.
module clkgen_ctl_slave #(
    parameter logic [6:0] DEV_ADDR    = 7'h69,
    parameter int         NREGS       = 6,
    parameter int         MAX_WR      = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pwr_dn,
    input  logic               scl_i,
    input  logic               sda_i,
    output logic               sda_pull_o,
    output logic [NREGS*8-1:0] ctl_bytes_o
);

    localparam int CNT_W = $clog2(MAX_WR + 3);
    localparam int IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

    logic             sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic             wr_en;
    logic [IDX_W-1:0] wr_idx;
    logic [7:0]       wr_data, rd_byte;
    logic [CNT_W-1:0] byte_pos;

    bus_line_sync #(.SYNC_STAGES(SYNC_STAGES)) i_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_lvl(sda_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    link_engine #(
        .DEV_ADDR(DEV_ADDR), .NREGS(NREGS), .MAX_WR(MAX_WR),
        .CNT_W(CNT_W), .IDX_W(IDX_W)
    ) i_engine (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .sda_lvl(sda_lvl),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .start_det(start_det),
        .stop_det(stop_det), .rd_byte(rd_byte), .sda_pull(sda_pull_o),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .byte_pos(byte_pos)
    );

    ctl_reg_bank #(.NREGS(NREGS), .CNT_W(CNT_W), .IDX_W(IDX_W)) i_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_pos(byte_pos), .rd_byte(rd_byte),
        .regs_flat(ctl_bytes_o)
    );

endmodule

// File: rtl/clkgen_ctl_checker.sv
// Port-level properties of clkgen_ctl_slave, bound into every instance.
// Assumes the bus master keeps SCL low for several system cycles per phase.
module clkgen_ctl_checker
    import clkgen_ctl_pkg::*;
#(
    parameter int NREGS = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pwr_dn,
    input logic               scl_i,
    input logic [NREGS*8-1:0] ctl_bytes_o,
    input logic               sda_pull_o
);

    logic [NREGS*8-1:0] dflt;

    // Build the expected power-up image.
    always_comb begin
        for (int i = 0; i < NREGS; i++) dflt[i*8 +: 8] = reg_default(i);
    end

    p_defaults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> ctl_bytes_o == dflt);

    p_pull_scl_low_r4: assert property (@(posedge clk) disable iff (!rst_n || pwr_dn)
        ($past(rst_n) && !$past(pwr_dn) && sda_pull_o != $past(sda_pull_o)) |-> !scl_i);

    p_reg_scl_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && ctl_bytes_o != $past(ctl_bytes_o)) |-> !scl_i);

    p_release_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn |=> !sda_pull_o);

    p_hold_pwrdn_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_dn && $past(pwr_dn) && $past(pwr_dn, 2) && $past(rst_n, 2)) |-> $stable(ctl_bytes_o));

endmodule

bind clkgen_ctl_slave clkgen_ctl_checker #(.NREGS(NREGS)) i_checker (
    .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .scl_i(scl_i),
    .ctl_bytes_o(ctl_bytes_o), .sda_pull_o(sda_pull_o)
);

// File: tb/test_clkgen_ctl_slave.sv
// Bench: bus master model, reference register image, random and directed frames.
module test_clkgen_ctl_slave;

    localparam int Q = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pwr_dn = 1'b0;
    logic        m_scl = 1'b1;
    logic        m_sda = 1'b1;
    logic        sda_pull;
    logic [47:0] ctl;
    logic        sda_line;

    int n_checks = 0;
    int n_err = 0;
    int pull_cycles = 0;

    logic [7:0] model [0:5];
    logic [7:0] wbuf  [0:15];
    logic [7:0] rbuf  [0:15];

    assign sda_line = m_sda & ~sda_pull;

    always #2 clk = ~clk;

    clkgen_ctl_slave i_clkgen_ctl_slave (
        .clk(clk), .rst_n(rst_n), .pwr_dn(pwr_dn), .scl_i(m_scl),
        .sda_i(sda_line), .sda_pull_o(sda_pull), .ctl_bytes_o(ctl)
    );

    always @(posedge clk) if (sda_pull) pull_cycles++;

    function automatic logic [7:0] exp_reset(input int k);
        logic [7:0] t [0:5];
        t[0] = 8'hF6; t[1] = 8'h3F; t[2] = 8'hE0;
        t[3] = 8'h7E; t[4] = 8'h00; t[5] = 8'h00;
        return t[k];
    endfunction

    function automatic logic [7:0] exp_stream(input int pos);
        if (pos == 0) return 8'd6;
        if (pos <= 6) return model[pos-1];
        return 8'h00;
    endfunction

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 6; k++) check(req, $sformatf("byte %0d", k), 32'(ctl[k*8 +: 8]), 32'(model[k]));
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; tick(Q);
        m_scl = 1'b1; tick(Q);
        m_sda = 1'b1; tick(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; tick(Q);
            m_scl = 1'b1; tick(2*Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = 1'b1; tick(Q);
        m_scl = 1'b1; tick(Q);
        ack = !sda_line;
        tick(Q);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            m_scl = 1'b1; tick(Q);
            b[i] = sda_line;
            tick(Q);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = give_ack ? 1'b0 : 1'b1; tick(Q);
        m_scl = 1'b1; tick(2*Q);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    // Start, address, command, count, n bytes from wbuf; returns ack count.
    task automatic wr_frame(input logic [7:0] addr, input int n, input bit do_stop, output int n_ack);
        bit a;
        n_ack = 0;
        bus_start();
        send_byte(addr, a); if (a) n_ack++;
        send_byte(8'($urandom), a); if (a) n_ack++;
        send_byte(8'($urandom), a); if (a) n_ack++;
        for (int i = 0; i < n; i++) begin
            send_byte(wbuf[i], a); if (a) n_ack++;
        end
        if (do_stop) bus_stop();
    endtask

    // Start, read address, n bytes into rbuf (last one not acknowledged).
    task automatic rd_frame(input int n, output bit addr_ack);
        bus_start();
        send_byte(8'hD3, addr_ack);
        for (int i = 0; i < n; i++) recv_byte(i < n-1, rbuf[i]);
        bus_stop();
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: run did not finish (all requirements)");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

    initial begin
        int na;
        bit aa;
        void'($urandom(32'd91357));
        for (int k = 0; k < 6; k++) model[k] = exp_reset(k);
        tick(5);
        rst_n = 1'b1;
        tick(5);

        // R1: power-up image
        check_regs("R1");
        check("R4", "idle pull", 32'(sda_pull), 32'd0);

        // R2: foreign address and an address differing only in bit 0 position
        for (int i = 0; i < 3; i++) wbuf[i] = 8'h11 * (i + 1);
        wr_frame(8'hA4, 3, 1'b1, na);
        check("R2", "acks to foreign address", 32'(na), 32'd0);
        wr_frame(8'hD0, 3, 1'b1, na);
        check("R2", "acks to near address", 32'(na), 32'd0);
        check_regs("R2");

        // R3 / R4: short write, acks on every byte
        wbuf[0] = 8'h5A; wbuf[1] = 8'hC3; wbuf[2] = 8'h81;
        wr_frame(8'hD2, 3, 1'b1, na);
        check("R4", "acks on 3-byte write", 32'(na), 32'd6);
        model[0] = 8'h5A; model[1] = 8'hC3; model[2] = 8'h81;
        check_regs("R3");

        // R5: 11 bytes, the last not acknowledged, only six stored
        for (int i = 0; i < 11; i++) wbuf[i] = 8'(8'h20 + i * 7);
        wr_frame(8'hD2, 11, 1'b1, na);
        check("R5", "acks on 11-byte write", 32'(na), 32'd13);
        for (int k = 0; k < 6; k++) model[k] = wbuf[k];
        check_regs("R5");

        // R6: read stream past the end
        rd_frame(9, aa);
        check("R6", "read address ack", 32'(aa), 32'd1);
        for (int i = 0; i < 9; i++) check("R6", $sformatf("stream %0d", i), 32'(rbuf[i]), 32'(exp_stream(i)));

        // R7: master NACK, then extra clocks without stop
        bus_start();
        send_byte(8'hD3, aa);
        recv_byte(1'b1, rbuf[0]);
        recv_byte(1'b0, rbuf[1]);
        pull_cycles = 0;
        recv_byte(1'b0, rbuf[2]);
        check("R7", "line after nack", 32'(rbuf[2]), 32'hFF);
        check("R7", "pull cycles after nack", 32'(pull_cycles), 32'd0);
        bus_stop();

        // R8: power-down ignores bus and keeps registers
        pwr_dn = 1'b1; tick(4);
        for (int i = 0; i < 4; i++) wbuf[i] = 8'hE1;
        wr_frame(8'hD2, 4, 1'b1, na);
        check("R8", "acks in power-down", 32'(na), 32'd0);
        rd_frame(1, aa);
        check("R8", "read ack in power-down", 32'(aa), 32'd0);
        check_regs("R8");
        pwr_dn = 1'b0; tick(4);
        check_regs("R8");

        // R9: write then repeated start into a read
        wbuf[0] = 8'h3C;
        wr_frame(8'hD2, 1, 1'b0, na);
        model[0] = 8'h3C;
        rd_frame(2, aa);
        check("R9", "read ack after repeated start", 32'(aa), 32'd1);
        check("R9", "count after repeated start", 32'(rbuf[0]), 32'd6);
        check("R9", "byte 0 after repeated start", 32'(rbuf[1]), 32'h3C);

        // R10: stop after two bytes leaves the rest intact
        wbuf[0] = 8'hA5; wbuf[1] = 8'h96;
        wr_frame(8'hD2, 2, 1'b1, na);
        model[0] = 8'hA5; model[1] = 8'h96;
        check_regs("R10");

        // Random write lengths and read-backs (R3, R5, R6)
        for (int it = 0; it < 8; it++) begin
            int n;
            int m;
            n = int'($urandom_range(0, 10));
            for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
            wr_frame(8'hD2, n, 1'b1, na);
            check("R5", "random write acks", 32'(na), 32'(n + 3));
            for (int i = 0; i < n && i < 6; i++) model[i] = wbuf[i];
            check_regs("R3");
            m = int'($urandom_range(1, 9));
            rd_frame(m, aa);
            for (int i = 0; i < m; i++) check("R6", $sformatf("random stream %0d", i), 32'(rbuf[i]), 32'(exp_stream(i)));
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule